// File: doc/BRIEF.md
# Paged I2C Byte Memory Slave

This block is a byte-wide memory of 2048 locations that answers as a slave on a two-wire I2C bus. The bus lines are sampled on a fast system clock. The block finds start and stop conditions and shifts bytes in and out. It acknowledges each byte it receives and keeps an 11-bit access pointer. The top three bits of that pointer come from a page field inside the slave address byte. The lower eight bits are held in a latch that survives from one transaction to the next.

A master can write one byte or a burst of bytes. It can read from wherever the last operation stopped, or it can read a burst. It can also pick an arbitrary start location: it writes only a word address, then issues a repeated start and reads. The data line is split into an input, an active-high output enable and an output held at zero, which makes an open-drain driver.

Top module: `i2c_page_mem`

## Requirements
- R1: After reset, and in idle, SDA is released (`sda_oe_o` low). A slave byte whose bits 7:4 differ from the device code (default 4'b1010) gets no ACK, and SDA stays released for the rest of that transaction.
- R2: The slave byte is laid out as bits 7:4 device code, bits 3:1 page (pointer bits 10:8), bit 0 direction (1 read, 0 write). In a write, the first following byte loads pointer bits 7:0. Each later byte is stored at the pointer.
- R3: The 11-bit pointer advances by one after every data byte written or sent. It carries from bit 7 into the page bits, and 0x7FF is followed by 0x000.
- R4: A write slave byte, then a word address, then a repeated start and a read slave byte returns data starting at {page, word address}.
- R5: A read with no word address starts at the pointer left by the previous operation, with bits 10:8 replaced by the page of the new slave byte.
- R6: Read data goes out MSB first. The first bit is driven after the SCL falling edge that ends the slave-address ACK. Every master ACK (SDA low in the 9th clock) makes the slave send the next sequential byte.
- R7: After a master NACK followed by a stop or a start, SDA is released. The next read with no word address resumes at the byte after the last one sent.
- R8: A stop or a start in the 9th clock of a read byte releases SDA at once, and no further byte is driven.
- R9: A start or stop inside a byte aborts the transfer. A partly received data byte is not stored.
- R10: The slave begins to pull SDA low only while SCL is low.
- R11: The slave pulls SDA low in the 9th clock of every byte it receives in an addressed write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High to pull SDA low |
| sda_o | output | 1 | Driven value of SDA, always 0 |

## Verification
Two events can meet in the master's acknowledge slot of a read: the sampling of the master's ACK, which would make the slave prepare and drive the next byte, and a stop or start condition from the master. The bench raises SCL with SDA low, so the slave samples an ACK, and then lets SDA rise to form a stop. In a second case it forms a repeated start in the same slot. Each case is judged by SDA being released while SCL is still high and by where the following current-address read resumes.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_MACK
  } slv_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_N-1];
      sda_d  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_N-1];
  assign sda_o      = sda_ff[SYNC_N-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // bus conditions: SDA moves while SCL is held high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          PAGE_W   = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [7:0]        rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              sda_oe_o
);
  localparam int LOW_W = ADDR_W - PAGE_W;

  slv_st_e           st;
  logic [3:0]        cnt;
  logic [7:0]        shreg;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] cur;
  logic              oe;
  logic              rw;
  logic              mack;
  logic              rx_st;

  assign rx_st = (st == ST_DEV) || (st == ST_WADR) || (st == ST_WDAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
      tx    <= '0;
      cur   <= '0;
      oe    <= 1'b0;
      rw    <= 1'b0;
      mack  <= 1'b1;
    end else if (start_i) begin
      st  <= ST_DEV;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (stop_i) begin
      st  <= ST_IDLE;
      cnt <= '0;
      oe  <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        if (rx_st && cnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_i};
          cnt   <= cnt + 4'd1;
        end
        if (st == ST_MACK) mack <= sda_i;
      end
      if (scl_fall_i) begin
        unique case (st)
          ST_DEV: if (cnt == 4'd8) begin
            if (shreg[7:4] == DEV_CODE) begin
              oe <= 1'b1;
              rw <= shreg[0];
              cur[ADDR_W-1:LOW_W] <= shreg[PAGE_W:1];
              st <= ST_DEV_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_DEV_ACK: begin
            if (rw) begin
              // first read bit goes out on the edge that ends the ACK
              oe  <= ~rdata_i[7];
              tx  <= {rdata_i[6:0], 1'b0};
              cur <= cur + ADDR_W'(1);
              cnt <= 4'd1;
              st  <= ST_TX;
            end else begin
              oe  <= 1'b0;
              cnt <= '0;
              st  <= ST_WADR;
            end
          end
          ST_WADR: if (cnt == 4'd8) begin
            cur[LOW_W-1:0] <= shreg[LOW_W-1:0];
            oe <= 1'b1;
            st <= ST_WADR_ACK;
          end
          ST_WADR_ACK, ST_WDAT_ACK: begin
            oe  <= 1'b0;
            cnt <= '0;
            st  <= ST_WDAT;
          end
          ST_WDAT: if (cnt == 4'd8) begin
            cur <= cur + ADDR_W'(1);
            oe  <= 1'b1;
            st  <= ST_WDAT_ACK;
          end
          ST_TX: begin
            if (cnt == 4'd8) begin
              oe  <= 1'b0;
              cnt <= '0;
              st  <= ST_MACK;
            end else begin
              oe  <= ~tx[7];
              tx  <= {tx[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
          ST_MACK: begin
            if (!mack) begin
              oe  <= ~rdata_i[7];
              tx  <= {rdata_i[6:0], 1'b0};
              cur <= cur + ADDR_W'(1);
              cnt <= 4'd1;
              st  <= ST_TX;
            end else begin
              oe <= 1'b0;
              st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_we_o    = scl_fall_i && !start_i && !stop_i && (st == ST_WDAT) && (cnt == 4'd8);
  assign mem_addr_o  = cur;
  assign mem_wdata_o = shreg;
  assign sda_oe_o    = oe;

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
  p_start_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st == ST_DEV) && (cnt == 4'd0) && !sda_oe_o);
  p_drive_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(!scl_i));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && (cur == '1)) |=> (cur == '0));
endmodule

// File: rtl/i2c_page_mem.sv
module i2c_page_mem #(
  parameter int         ADDR_W   = 11,
  parameter int         PAGE_W   = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter int         SYNC_N   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic sda_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  i2c_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slave_fsm #(
    .ADDR_W   (ADDR_W),
    .PAGE_W   (PAGE_W),
    .DEV_CODE (DEV_CODE)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_s),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .rdata_i     (mem_rdata),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .sda_oe_o    (sda_oe_o)
  );

  i2c_mem_array #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );

  assign sda_o = 1'b0;
endmodule

// File: tb/sim_i2c_page_mem.sv
module sim_i2c_page_mem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, sda_out, sda_line;
  int   total = 0;
  int   bad = 0;
  int   drive_hi = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  logic [7:0]  ref_mem [0:2047];
  logic [10:0] ref_adr = '0;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_page_mem u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .sda_o    (sda_out)
  );

  // R10 monitor: pull-down must not start while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl) drive_hi++;
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; q(); scl = 1'b1; q(); b = sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_bits(output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    recv_bits(d);
    send_bit(~mack);
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] dev(input logic [2:0] pg, input logic rd);
    return {4'b1010, pg, rd};
  endfunction

  task automatic write_seq(input logic [2:0] pg, input logic [7:0] low, input int n, input int seed);
    logic a;
    logic [7:0] d;
    i2c_start();
    send_byte(dev(pg, 1'b0), a); check("R11 dev ack", a, 1);
    send_byte(low, a);            check("R11 word ack", a, 1);
    ref_adr = {pg, low};
    for (int i = 0; i < n; i++) begin
      d = pat(seed, i);
      send_byte(d, a); check("R11 data ack", a, 1);
      ref_mem[ref_adr] = d;
      ref_adr = ref_adr + 11'd1;
    end
    i2c_stop();
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      check(req, d, ref_mem[ref_adr]);
      ref_adr = ref_adr + 11'd1;
    end
  endtask

  task automatic read_sel(input logic [2:0] pg, input logic [7:0] low, input int n, input string req);
    logic a;
    i2c_start();
    send_byte(dev(pg, 1'b0), a); check(req, a, 1);
    send_byte(low, a);            check(req, a, 1);
    ref_adr = {pg, low};
    i2c_start();
    send_byte(dev(pg, 1'b1), a); check(req, a, 1);
    read_body(n, req);
    i2c_stop();
  endtask

  task automatic read_cur(input logic [2:0] pg, input int n, input string req);
    logic a;
    i2c_start();
    send_byte(dev(pg, 1'b1), a); check(req, a, 1);
    ref_adr[10:8] = pg;
    read_body(n, req);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    check("R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle release", sda_oe, 0);

    // R1: foreign device codes
    i2c_start();
    send_byte(8'b1011_0001, a); check("R1 no ack 1011", a, 0);
    check("R1 released after", sda_oe, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'b0010_1100, a); check("R1 no ack 0010", a, 0);
    i2c_stop();

    // R2 R4 R6: every page, burst write then selective burst read
    for (int p = 0; p < 8; p++) begin
      write_seq(3'(p), 8'h03, 10, p);
      read_sel(3'(p), 8'h03, 10, (p % 2 == 0) ? "R4 sel read" : "R6 seq read");
    end
    read_sel(3'd5, 8'h07, 1, "R2 stored byte");

    // R3: carry into page bits, and full wrap
    write_seq(3'd2, 8'hFE, 4, 20);
    read_sel(3'd2, 8'hFE, 4, "R3 carry");
    write_seq(3'd7, 8'hFE, 5, 21);
    read_sel(3'd7, 8'hFE, 5, "R3 wrap");
    check("R3 pointer after wrap", ref_adr, 11'h003);

    // R5: current-address reads resume at the latch with a new page
    read_cur(3'd0, 2, "R5 cur read p0");
    read_cur(3'd1, 2, "R5 cur read p1");

    // R7: NACK then repeated start
    i2c_start();
    send_byte(dev(3'd1, 1'b1), a); check("R7 ack", a, 1);
    ref_adr[10:8] = 3'd1;
    recv_byte(d, 1'b0);
    check("R7 data", d, ref_mem[ref_adr]);
    ref_adr = ref_adr + 11'd1;
    check("R7 released after nack", sda_oe, 0);
    i2c_start();
    send_byte(dev(3'd1, 1'b1), a); check("R7 ack again", a, 1);
    recv_byte(d, 1'b0);
    check("R7 resume", d, ref_mem[ref_adr]);
    ref_adr = ref_adr + 11'd1;
    i2c_stop();

    // R8: ACK sampled, then stop in the same 9th clock
    i2c_start();
    send_byte(dev(3'd2, 1'b1), a); check("R8 ack", a, 1);
    ref_adr[10:8] = 3'd2;
    recv_bits(d);
    check("R8 data", d, ref_mem[ref_adr]);
    ref_adr = ref_adr + 11'd1;
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
    check("R8 stop release", sda_oe, 0);
    q();
    check("R8 line high", sda_line, 1);
    read_cur(3'd2, 1, "R8 resume after stop");

    // R8: start in the 9th clock
    i2c_start();
    send_byte(dev(3'd3, 1'b1), a); check("R8 ack", a, 1);
    ref_adr[10:8] = 3'd3;
    recv_bits(d);
    check("R8 data", d, ref_mem[ref_adr]);
    ref_adr = ref_adr + 11'd1;
    i2c_start();
    check("R8 start release", sda_oe, 0);
    send_byte(dev(3'd3, 1'b1), a); check("R8 restart ack", a, 1);
    recv_byte(d, 1'b0);
    check("R8 resume after start", d, ref_mem[ref_adr]);
    ref_adr = ref_adr + 11'd1;
    i2c_stop();

    // R9: start inside a data byte, partial byte dropped
    i2c_start();
    send_byte(dev(3'd6, 1'b0), a); check("R9 ack", a, 1);
    send_byte(8'h05, a);            check("R9 word ack", a, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    i2c_start();
    check("R9 released", sda_oe, 0);
    i2c_stop();
    read_sel(3'd6, 8'h05, 1, "R9 not stored");

    check("R10 drive while scl high", drive_hi, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule